// File: doc/BRIEF.md
# Scratch Readback and Signature Test Window

This block is a small memory-mapped test target. It answers a simple bus that carries an address, an access size and write data, with separate read and write strobes. Two regions are decoded. One is a 64-byte scratch store, with reads and writes of 1, 2, 4 or 8 bytes at any byte position. The other is an 8-byte window that ignores every write and answers every read with a fixed signature, so software can time a bare bus round trip.

All read data is registered. The result appears on `rdata` one clock after the read strobe, together with a one-cycle `rvalid` pulse. Data is little-endian. Lane 0 (bits 7:0) of `wdata` and `rdata` carries the byte at the lowest address of the access. Any address outside both regions reads as all ones and ignores writes.

Top module: `test_window`

## Requirements
- R1: After a synchronous active-low reset, `rdata` is 0, `rvalid` is 0 and all 64 scratch bytes read back as zero.
- R2: `rvalid` is high in exactly the cycle after each cycle with `rd_en` high and low otherwise. `rdata` changes only in a cycle that follows a read strobe.
- R3: `size` encodes the access width as 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. The scratch region covers `SCRATCH_BASE` to `SCRATCH_BASE+63` (default 0x40 to 0x7F), and the byte offset inside it is the address masked with 0x3F.
- R4: A scratch write stores lane j of `wdata` into the byte at offset+j, for j below the access width, and leaves every other scratch byte unchanged.
- R5: A scratch read returns the byte at offset+j in lane j, for j below the access width. Lanes at or above the width read as zero.
- R6: A scratch access whose offset plus width exceeds 64 is rejected. A rejected write changes nothing, and a rejected read returns all ones.
- R7: A read at offset 0 of the signature window (`NOP_BASE`, default 0x00) returns the 32-bit `SIGNATURE` in the low bytes. An 8-byte read returns it in both 32-bit halves. Lanes beyond the access width read 0xFF.
- R8: A read at signature-window offset k (1..7) starts with every lane at 0xFF. Lane j then holds byte k+j of an 8-byte pattern made of the signature twice (pattern byte i = signature byte i mod 4), for j < min(8-k, width).
- R9: Writes of any size at any offset of the signature window are accepted and change neither the scratch contents nor later signature reads.
- R10: A read of an address in neither region returns all 64 bits set.
- R11: A write to an address in neither region changes no scratch byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current address |
| rd_en | input | 1 | Read strobe for the current address |
| addr | input | AW (8) | Byte address of the access |
| size | input | 2 | Access width code: 0=1, 1=2, 2=4, 3=8 bytes |
| wdata | input | 64 | Write data, lane 0 = lowest address |
| rdata | output | 64 | Registered read data |
| rvalid | output | 1 | One-cycle pulse marking `rdata` as the answer to the previous read |

## Verification
The bench keeps the default parameters: an 8-bit address, the scratch window at 0x40, the signature window at 0x00 and signature 0xCAFEF00D. With an 8-bit address space, random draws cover both regions, the unmapped gap between them and the unmapped upper half. Every offset k of the signature window meets every access width, so each cut point of the 0xFF fill is reached. Every scratch offset near 63 meets every width, so the accept/reject edge is crossed from both sides.

// File: rtl/tw_pkg.sv
// Shared definitions for the test window.
// Assumes: 64-bit data bus made of 8 byte lanes.
package tw_pkg;

    localparam int LANES = 8;

    // Access width codes carried on the size input.
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_HALF  = 2'd1,
        SZ_WORD  = 2'd2,
        SZ_DWORD = 2'd3
    } acc_size_e;

    // Number of bytes moved by an access of the given width code.
    function automatic logic [3:0] size_to_bytes(input logic [1:0] sz);
        return 4'd1 << sz;
    endfunction

endpackage

// File: rtl/tw_decode.sv
// Address decoder for the test window.
// Splits an access into signature-window and scratch hits. Gives the offset
// inside each region and the byte count. A scratch hit needs the whole access
// to fit in the scratch store.
// Assumes: SCRATCH_BASE is aligned to SCRATCH_BYTES, NOP_BASE to 8 bytes.
module tw_decode #(
    parameter int          AW            = 8,
    parameter int          SCRATCH_BYTES = 64,
    parameter int unsigned SCRATCH_BASE  = 'h40,
    parameter int unsigned NOP_BASE      = 'h00
) (
    input  logic [AW-1:0]                      addr,
    input  logic [1:0]                         size,
    output logic                               scr_hit,
    output logic                               nop_hit,
    output logic [$clog2(SCRATCH_BYTES)-1:0]   scr_off,
    output logic [2:0]                         nop_off,
    output logic [3:0]                         nbytes
);
    import tw_pkg::*;

    localparam int OFF_W = $clog2(SCRATCH_BYTES);
    localparam int OW1   = OFF_W + 1;
    localparam logic [AW-1:0]  SB    = AW'(SCRATCH_BASE);
    localparam logic [AW-1:0]  NB    = AW'(NOP_BASE);
    localparam logic [OW1-1:0] LIMIT = OW1'(SCRATCH_BYTES);

    logic in_scr_range;
    logic fits;

    // Region match and offset extraction.
    always_comb begin
        nbytes       = size_to_bytes(size);
        scr_off      = addr[OFF_W-1:0];
        nop_off      = addr[2:0];
        in_scr_range = (addr[AW-1:OFF_W] == SB[AW-1:OFF_W]);
        fits         = ({1'b0, scr_off} + OW1'(nbytes)) <= LIMIT;
        nop_hit      = (addr[AW-1:3] == NB[AW-1:3]);
        scr_hit      = in_scr_range && fits && !nop_hit;
    end

endmodule

// File: rtl/tw_scratch.sv
// Byte-addressed scratch store with little-endian lane merging.
// A write puts wdata lane j into byte off+j for j < nbytes. A read returns
// byte off+j in lane j and zero in lanes at or above nbytes.
// Assumes: the caller asserts wr_hit only for accesses that fit the store.
module tw_scratch #(
    parameter int SCRATCH_BYTES = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_hit,
    input  logic [$clog2(SCRATCH_BYTES)-1:0]  off,
    input  logic [3:0]                        nbytes,
    input  logic [63:0]                       wdata,
    output logic [63:0]                       rd_bytes
);
    import tw_pkg::*;

    localparam int OFF_W = $clog2(SCRATCH_BYTES);
    localparam int OW1   = OFF_W + 1;

    logic [7:0]                 mem      [SCRATCH_BYTES];
    logic [7:0]                 wr_lane  [LANES];
    logic [SCRATCH_BYTES-1:0]   byte_sel;
    logic [2:0]                 lane_of  [SCRATCH_BYTES];
    logic [SCRATCH_BYTES*8-1:0] mem_flat;

    // Split write data into byte lanes.
    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            wr_lane[j] = wdata[j*8 +: 8];
        end
    end

    // Per-byte write select and source lane.
    always_comb begin
        for (int i = 0; i < SCRATCH_BYTES; i++) begin
            logic [OFF_W-1:0] rel;
            rel         = OFF_W'(i) - off;
            lane_of[i]  = rel[2:0];
            byte_sel[i] = wr_hit && (OW1'(rel) < OW1'(nbytes));
        end
    end

    // Storage update with reset to zero.
    always_ff @(posedge clk) begin
        for (int i = 0; i < SCRATCH_BYTES; i++) begin
            if (!rst_n) begin
                mem[i] <= 8'h00;
            end else if (byte_sel[i]) begin
                mem[i] <= wr_lane[lane_of[i]];
            end
        end
    end

    // Read extraction, zero above the access width.
    always_comb begin
        rd_bytes = '0;
        for (int j = 0; j < LANES; j++) begin
            if (4'(j) < nbytes) begin
                rd_bytes[j*8 +: 8] = mem[off + OFF_W'(j)];
            end
        end
    end

    // Flat view of the store for checking.
    genvar g;
    generate
        for (g = 0; g < SCRATCH_BYTES; g++) begin : g_flat
            assign mem_flat[g*8 +: 8] = mem[g];
        end
    endgenerate

    AST_SCRATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(mem_flat)); // R6

endmodule

// File: rtl/tw_nop_pattern.sv
// Read answer for the signature window.
// Lane j carries byte k+j of the signature repeated twice, while
// j < nbytes and k+j < 8. Every other lane is 0xFF.
// Assumes: purely combinational; the caller registers the result.
module tw_nop_pattern #(
    parameter logic [31:0] SIGNATURE = 32'hCAFEF00D
) (
    input  logic [2:0]  k,
    input  logic [3:0]  nbytes,
    output logic [63:0] data
);
    import tw_pkg::*;

    logic [7:0] pat [LANES];

    // Build the doubled signature as a byte array.
    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            pat[i] = SIGNATURE[(i % 4)*8 +: 8];
        end
    end

    // Fill with 0xFF, then place the slice starting at byte k.
    always_comb begin
        data = '1;
        for (int j = 0; j < LANES; j++) begin
            logic [3:0] idx;
            idx = 4'(k) + 4'(j);
            if ((4'(j) < nbytes) && (idx < 4'd8)) begin
                data[j*8 +: 8] = pat[idx[2:0]];
            end
        end
    end

endmodule

// File: rtl/test_window.sv
// Test window top level.
// Decodes each access into the scratch store, the signature window or
// unmapped space. It registers the read answer and pulses rvalid one cycle
// after each read strobe. Writes to the signature window and to unmapped
// space are dropped.
// Assumes: read and write strobes are not raised in the same cycle.
module test_window #(
    parameter int          AW            = 8,
    parameter int          SCRATCH_BYTES = 64,
    parameter int unsigned SCRATCH_BASE  = 'h40,
    parameter int unsigned NOP_BASE      = 'h00,
    parameter logic [31:0] SIGNATURE     = 32'hCAFEF00D
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    input  logic [63:0]   wdata,
    output logic [63:0]   rdata,
    output logic          rvalid
);
    localparam int OFF_W = $clog2(SCRATCH_BYTES);

    logic             scr_hit;
    logic             nop_hit;
    logic [OFF_W-1:0] scr_off;
    logic [2:0]       nop_off;
    logic [3:0]       nbytes;
    logic [63:0]      scr_data;
    logic [63:0]      nop_data;
    logic [63:0]      rd_next;

    tw_decode #(
        .AW            (AW),
        .SCRATCH_BYTES (SCRATCH_BYTES),
        .SCRATCH_BASE  (SCRATCH_BASE),
        .NOP_BASE      (NOP_BASE)
    ) u_decode (
        .addr    (addr),
        .size    (size),
        .scr_hit (scr_hit),
        .nop_hit (nop_hit),
        .scr_off (scr_off),
        .nop_off (nop_off),
        .nbytes  (nbytes)
    );

    tw_scratch #(
        .SCRATCH_BYTES (SCRATCH_BYTES)
    ) u_scratch (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_hit   (wr_en && scr_hit),
        .off      (scr_off),
        .nbytes   (nbytes),
        .wdata    (wdata),
        .rd_bytes (scr_data)
    );

    tw_nop_pattern #(
        .SIGNATURE (SIGNATURE)
    ) u_nop (
        .k      (nop_off),
        .nbytes (nbytes),
        .data   (nop_data)
    );

    // Select the read answer by region; unmapped reads all ones.
    always_comb begin
        if (nop_hit) begin
            rd_next = nop_data;
        end else if (scr_hit) begin
            rd_next = scr_data;
        end else begin
            rd_next = '1;
        end
    end

    // Register read data and the valid pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en) begin
                rdata <= rd_next;
            end
        end
    end

    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid); // R2
    AST_RVALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid); // R2
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata)); // R2
    AST_UNMAPPED_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !nop_hit && !scr_hit) |=> (rdata == '1)); // R10
    AST_NOP_DOUBLE_SIG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && nop_hit && (addr[2:0] == 3'd0) && (size == 2'd3))
        |=> (rdata == {SIGNATURE, SIGNATURE})); // R7

endmodule

// File: tb/sim_test_window.sv
module sim_test_window;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] SIG        = 32'hCAFEF00D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [1:0]  size = '0;
    logic [63:0] wdata = '0;
    logic [63:0] rdata;
    logic        rvalid;

    int total = 0;
    int bad   = 0;
    logic [7:0] model [64];

    always #(CLK_PERIOD/2) clk = ~clk;

    test_window u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .size   (size),
        .wdata  (wdata),
        .rdata  (rdata),
        .rvalid (rvalid)
    );

    function automatic logic [63:0] exp_read(input logic [7:0] a, input logic [1:0] sz);
        int n = 1 << sz;
        logic [63:0] r;
        if (a[7:3] == 5'd0) begin
            r = '1;
            for (int j = 0; j < 8; j++) begin
                int idx = int'(a[2:0]) + j;
                if (j < n && idx < 8) r[j*8 +: 8] = SIG[(idx % 4)*8 +: 8];
            end
        end else if (a[7:6] == 2'b01 && int'(a[5:0]) + n <= 64) begin
            r = '0;
            for (int j = 0; j < n; j++) r[j*8 +: 8] = model[int'(a[5:0]) + j];
        end else begin
            r = '1;
        end
        return r;
    endfunction

    task automatic model_write(input logic [7:0] a, input logic [1:0] sz, input logic [63:0] d);
        int n = 1 << sz;
        if (a[7:6] == 2'b01 && int'(a[5:0]) + n <= 64) begin
            for (int j = 0; j < n; j++) model[int'(a[5:0]) + j] = d[j*8 +: 8];
        end
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [1:0] sz, input logic [63:0] d);
        @(negedge clk);
        addr = a; size = sz; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, sz, d);
    endtask

    task automatic do_read(input logic [7:0] a, input logic [1:0] sz, input string req);
        @(negedge clk);
        addr = a; size = sz; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk(req, {63'd0, rvalid}, 64'd1);
        chk(req, rdata, exp_read(a, sz));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [63:0] held;
        void'($urandom(32'd4242));
        for (int i = 0; i < 64; i++) model[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rdata", rdata, 64'd0);
        chk("R1 rvalid", {63'd0, rvalid}, 64'd0);
        rst_n = 1'b1;
        do_read(8'h40, 2'd3, "R1 scratch zero");
        do_read(8'h78, 2'd3, "R1 scratch zero top");

        // R2: pulse drops and data holds
        held = rdata;
        @(negedge clk);
        chk("R2 rvalid low", {63'd0, rvalid}, 64'd0);
        chk("R2 rdata hold", rdata, held);

        // R3 R4 R5: merging and lane order
        do_write(8'h40, 2'd3, 64'h8877665544332211);
        do_write(8'h43, 2'd0, 64'hFFFF_FFFF_FFFF_FFA5);
        do_write(8'h45, 2'd1, 64'h0000_0000_0000_C3B4);
        do_read(8'h40, 2'd3, "R4 merge");
        do_read(8'h43, 2'd0, "R5 byte");
        do_read(8'h42, 2'd2, "R5 word odd");
        do_read(8'h47, 2'd1, "R3 half");

        // R6: boundary of the scratch store
        do_write(8'h7F, 2'd0, 64'h5A);
        do_write(8'h7F, 2'd1, 64'h1234);
        do_write(8'h7C, 2'd3, 64'h1111_2222_3333_4444);
        do_read(8'h7F, 2'd0, "R6 last byte");
        do_read(8'h78, 2'd3, "R6 last dword");
        do_read(8'h7E, 2'd2, "R6 reject read");
        do_read(8'h79, 2'd3, "R6 reject dword");

        // R7 R8: signature window every offset and width
        for (int k = 0; k < 8; k++) begin
            for (int s = 0; s < 4; s++) begin
                do_read(8'(k), 2'(s), (k == 0) ? "R7 sig base" : "R8 sig offset");
            end
        end

        // R9: writes to the signature window
        for (int k = 0; k < 8; k++) do_write(8'(k), 2'd3, 64'hDEAD_BEEF_DEAD_BEEF);
        do_read(8'h00, 2'd3, "R9 sig unchanged");
        do_read(8'h05, 2'd2, "R9 sig offset unchanged");
        do_read(8'h40, 2'd3, "R9 scratch unchanged");

        // R10 R11: unmapped space
        do_write(8'h20, 2'd3, 64'h0123_4567_89AB_CDEF);
        do_write(8'hC0, 2'd3, 64'h0123_4567_89AB_CDEF);
        do_read(8'h20, 2'd0, "R10 gap");
        do_read(8'h90, 2'd3, "R10 upper");
        do_read(8'h08, 2'd1, "R10 after sig");
        do_read(8'h40, 2'd3, "R11 scratch unchanged");

        // Random mix
        for (int t = 0; t < 800; t++) begin
            int r = $urandom % 4;
            logic [7:0] a;
            logic [1:0] sz = 2'($urandom % 4);
            case (r)
                0:       a = 8'($urandom % 8);
                1, 2:    a = 8'h40 + 8'($urandom % 64);
                default: a = 8'($urandom % 256);
            endcase
            if ($urandom % 2) do_write(a, sz, {$urandom, $urandom});
            else do_read(a, sz, "R5 R8 R10 random");
        end
        for (int i = 0; i < 64; i += 8) do_read(8'h40 + 8'(i), 2'd3, "R4 final sweep");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule